// File: doc/BRIEF.md
# Direct-Mapped One-Bit Branch History Predictor

This block holds one taken/not-taken history bit for each slot of a small direct-mapped table. The low bits of an instruction's word address select the slot, and the table keeps no tags. In every cycle the fetch side presents its program counter together with that instruction's branch target. The block returns the prediction and the next fetch address. That address is the target when the stored bit reads taken, and the sequential address (PC + 4) when it reads not taken.

Later in the pipeline, the resolution side presents a resolved branch: its address, its real outcome and its target. The block classifies each resolution into one of three named kinds:
- `RES_IDLE`: no resolution is presented.
- `RES_AGREE`: the stored bit already equals the outcome. Nothing changes.
- `RES_FLIP`: the stored bit disagrees with the outcome. In that same cycle the block pulses a flush of the younger fetch, decode and execute stages and presents the correct-path restart address. At the clock edge it inverts the slot's bit.

These kinds are decoded fresh each cycle and are not a stored state. The only storage is the table itself.

Top module: `branch_hist_predictor`

## Requirements
- R1: After reset every table slot reads not taken, so a lookup at any index gives `pred_taken` = 0.
- R2: The slot index is PC bits [IDX_W+1:2]. PC bits [1:0] and all bits above IDX_W+1 do not affect which slot is read or written.
- R3: `pred_taken` equals the stored bit of the looked-up slot. `next_pc` is `look_target` when that bit is 1, and `look_pc` + 4 when it is 0.
- R4: When `upd_valid` is 1 and `upd_taken` differs from the slot's stored bit, `flush` is 1 in that same cycle. `redirect_pc` is then `upd_target` if `upd_taken` is 1, or `upd_pc` + 4 if it is 0.
- R5: After such a mispredicted resolution, the slot's bit is inverted and reads equal to `upd_taken` from the next cycle on.
- R6: When the resolved outcome equals the stored bit, `flush` stays 0 and the slot keeps its value.
- R7: While `upd_valid` is 0, `flush` is 0 and no slot changes.
- R8: A lookup and a resolution to the same slot in the same cycle return the bit held before that cycle's write. The write is seen from the next cycle.
- R9: `flush` lasts one cycle per mispredicted resolution. If the same resolution is presented again in the following cycle, it agrees with the corrected bit and does not flush.
- R10: A resolution changes at most its own slot. Every other slot keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the table |
| look_pc | input | ADDR_W | Fetch address to predict |
| look_target | input | ADDR_W | Branch target of the fetched instruction |
| pred_taken | output | 1 | Stored history bit for `look_pc` |
| next_pc | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |
| upd_target | input | ADDR_W | Target of the resolved branch |
| flush | output | 1 | Discard younger IF/ID/EX work this cycle |
| redirect_pc | output | ADDR_W | Correct-path fetch address, valid while `flush` is 1 |

## Verification
Random lookups and resolutions are drawn mostly from a handful of slots. This makes agreeing and disagreeing resolutions both frequent, so the test can tell a correct invert-on-miss from a blind write or from no write at all. Lookup addresses with scrambled upper and low two bits separate proper index extraction from use of the wrong address bits. Directed same-slot lookup-plus-resolution cycles distinguish read-before-write from write-through. A repeated resolution in consecutive cycles shows that the flush does not stretch. A full sweep of every slot after reset and after targeted writes shows the clear state and that neighbouring slots are untouched.

// File: rtl/bpht_pkg.sv
package bpht_pkg;

    typedef enum logic [1:0] {
        RES_IDLE  = 2'd0,
        RES_AGREE = 2'd1,
        RES_FLIP  = 2'd2
    } res_kind_e;

endpackage

// File: rtl/bpht_store.sv
module bpht_store #(
    parameter int IDX_W = 6,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit,
    output logic [DEPTH-1:0] hist_q
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hist_q[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                hist_q[g] <= wr_bit;
            end
        end
    end

endmodule

// File: rtl/bpht_lookup.sv
module bpht_lookup #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic [DEPTH-1:0]  hist_q,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] target,
    output logic              pred,
    output logic [ADDR_W-1:0] next_pc
);

    logic [IDX_W-1:0]  slot;
    logic [ADDR_W-1:0] seq_pc;

    always_comb begin
        slot    = pc[IDX_W+1:2];
        seq_pc  = pc + ADDR_W'(4);
        pred    = hist_q[slot];
        next_pc = pred ? target : seq_pc;
    end

endmodule

// File: rtl/bpht_resolve.sv
module bpht_resolve
    import bpht_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic [DEPTH-1:0]  hist_q,
    input  logic              valid,
    input  logic [ADDR_W-1:0] pc,
    input  logic              taken,
    input  logic [ADDR_W-1:0] target,
    output res_kind_e         kind,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              wr_bit,
    output logic              flush,
    output logic [ADDR_W-1:0] redirect_pc
);

    logic stored;

    always_comb begin
        wr_idx = pc[IDX_W+1:2];
        stored = hist_q[wr_idx];
        if (!valid) begin
            kind = RES_IDLE;
        end else if (stored == taken) begin
            kind = RES_AGREE;
        end else begin
            kind = RES_FLIP;
        end
    end

    always_comb begin
        wr_en       = 1'b0;
        wr_bit      = stored;
        flush       = 1'b0;
        redirect_pc = pc + ADDR_W'(4);
        unique case (kind)
            RES_IDLE: begin
            end
            RES_AGREE: begin
            end
            RES_FLIP: begin
                wr_en       = 1'b1;
                wr_bit      = ~stored;
                flush       = 1'b1;
                redirect_pc = taken ? target : pc + ADDR_W'(4);
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/branch_hist_predictor.sv
module branch_hist_predictor
    import bpht_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] look_pc,
    input  logic [ADDR_W-1:0] look_target,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] next_pc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target,
    output logic              flush,
    output logic [ADDR_W-1:0] redirect_pc
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] hist_q;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_bit;
    res_kind_e        res_kind;

    bpht_store #(.IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_bit (wr_bit),
        .hist_q (hist_q)
    );

    bpht_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lookup (
        .hist_q  (hist_q),
        .pc      (look_pc),
        .target  (look_target),
        .pred    (pred_taken),
        .next_pc (next_pc)
    );

    bpht_resolve #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_resolve (
        .hist_q      (hist_q),
        .valid       (upd_valid),
        .pc          (upd_pc),
        .taken       (upd_taken),
        .target      (upd_target),
        .kind        (res_kind),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_bit      (wr_bit),
        .flush       (flush),
        .redirect_pc (redirect_pc)
    );

endmodule

// File: rtl/branch_hist_predictor_chk.sv
module branch_hist_predictor_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    localparam int DEPTH = 1 << IDX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DEPTH-1:0]  hist_q,
    input logic [ADDR_W-1:0] look_pc,
    input logic [ADDR_W-1:0] look_target,
    input logic              pred_taken,
    input logic [ADDR_W-1:0] next_pc,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_pc,
    input logic              upd_taken,
    input logic [ADDR_W-1:0] upd_target,
    input logic              flush,
    input logic [ADDR_W-1:0] redirect_pc
);

    logic [IDX_W-1:0] li;
    logic [IDX_W-1:0] ui;

    always_comb begin
        li = look_pc[IDX_W+1:2];
        ui = upd_pc[IDX_W+1:2];
    end

    assert_pred_is_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken == hist_q[li]);

    assert_next_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        next_pc == (pred_taken ? look_target : look_pc + ADDR_W'(4)));

    assert_flush_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> redirect_pc == (upd_taken ? upd_target : upd_pc + ADDR_W'(4)));

    assert_miss_flushes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && hist_q[ui] != upd_taken) |-> flush);

    assert_resolved_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> hist_q[$past(ui)] == $past(upd_taken));

    assert_agree_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && hist_q[ui] == upd_taken) |-> !flush);

    assert_idle_no_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |-> !flush);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(hist_q));

    assert_one_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(hist_q ^ $past(hist_q)) <= 1);

endmodule

bind branch_hist_predictor branch_hist_predictor_chk #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hist_q      (hist_q),
    .look_pc     (look_pc),
    .look_target (look_target),
    .pred_taken  (pred_taken),
    .next_pc     (next_pc),
    .upd_valid   (upd_valid),
    .upd_pc      (upd_pc),
    .upd_taken   (upd_taken),
    .upd_target  (upd_target),
    .flush       (flush),
    .redirect_pc (redirect_pc)
);

// File: tb/branch_hist_predictor_test.sv
module branch_hist_predictor_test;

    localparam int ADDR_W = 32;
    localparam int IDX_W  = 6;
    localparam int DEPTH  = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] look_pc, look_target, upd_pc, upd_target;
    logic              upd_valid, upd_taken;
    logic              pred_taken, flush;
    logic [ADDR_W-1:0] next_pc, redirect_pc;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  model [DEPTH];
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    branch_hist_predictor #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .look_pc(look_pc), .look_target(look_target),
        .pred_taken(pred_taken), .next_pc(next_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target), .flush(flush), .redirect_pc(redirect_pc)
    );

    function automatic int slot_of(logic [ADDR_W-1:0] a);
        return int'(a[IDX_W+1:2]);
    endfunction

    function automatic logic [ADDR_W-1:0] exp_next(bit p, logic [ADDR_W-1:0] pc,
                                                   logic [ADDR_W-1:0] tg);
        return p ? tg : pc + 32'd4;
    endfunction

    task automatic chk(bit ok, string req, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] pc_for(int s);
        logic [ADDR_W-1:0] r;
        r = $urandom;
        r[IDX_W+1:2] = IDX_W'(s);
        return r;
    endfunction

    // One cycle: drive, check combinational outputs, then advance the model at the edge.
    task automatic step(logic [ADDR_W-1:0] lpc, logic [ADDR_W-1:0] ltg, bit uv,
                        logic [ADDR_W-1:0] upc, bit ut, logic [ADDR_W-1:0] utg, string ptag);
        bit ep, flip;
        int li, ui;
        string ftag;
        @(negedge clk);
        look_pc = lpc; look_target = ltg;
        upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
        #1;
        li = slot_of(lpc);
        ui = slot_of(upc);
        ep = model[li];
        flip = uv && (model[ui] != ut);
        chk(pred_taken == ep, ptag, 32'(pred_taken), 32'(ep));
        chk(next_pc == exp_next(ep, lpc, ltg), "R3", next_pc, exp_next(ep, lpc, ltg));
        ftag = flip ? "R4" : (uv ? "R6" : "R7");
        chk(flush == flip, ftag, 32'(flush), 32'(flip));
        if (flip)
            chk(redirect_pc == exp_next(ut, upc, utg), "R4", redirect_pc, exp_next(ut, upc, utg));
        if (uv) model[ui] = ut;
    endtask

    task automatic sweep(string tag);
        for (int s = 0; s < DEPTH; s++)
            step(pc_for(s), $urandom, 1'b0, 32'd0, 1'b0, 32'd0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int s = 0; s < DEPTH; s++) model[s] = 1'b0;
        rst_n = 1'b0;
        look_pc = '0; look_target = '0; upd_valid = 1'b0;
        upd_pc = '0; upd_taken = 1'b0; upd_target = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every slot not taken after reset
        sweep("R1");

        // R2: write via an address with scrambled low and high bits, read via another alias
        step(32'h0, 32'h0, 1'b1, 32'hABCD_0017, 1'b1, 32'h0000_4000, "R3");
        step(32'h1234_5617, 32'h0000_8000, 1'b0, 32'd0, 1'b0, 32'd0, "R2");
        step(32'hFFFF_FF16, 32'h0000_9000, 1'b0, 32'd0, 1'b0, 32'd0, "R2");

        // R8: lookup and flip on the same slot in the same cycle sees the old bit
        step(32'h0000_0020, 32'h0000_1000, 1'b1, 32'h5000_0020, 1'b1, 32'h0000_2000, "R8");
        step(32'h0000_0020, 32'h0000_1000, 1'b0, 32'd0, 1'b0, 32'd0, "R5");

        // R9: same resolution held for two cycles flushes only once
        step(32'h0, 32'h0, 1'b1, 32'h0000_0044, 1'b1, 32'h0000_3000, "R3");
        step(32'h0, 32'h0, 1'b1, 32'h0000_0044, 1'b1, 32'h0000_3000, "R9");
        // not-taken correction back to PC+4 redirect
        step(32'h0000_0044, 32'h0000_3000, 1'b1, 32'h0000_0044, 1'b0, 32'h0000_3000, "R8");

        // R10: neighbouring slots unchanged after targeted writes
        sweep("R10");

        // random mix concentrated on a few slots
        for (int it = 0; it < 2000; it++) begin
            logic [ADDR_W-1:0] lp, up;
            lp = pc_for(int'($urandom_range(0, 7)));
            up = ($urandom_range(0, 3) == 0) ? lp : pc_for(int'($urandom_range(0, 7)));
            step(lp, $urandom, bit'($urandom_range(0, 3) != 0), up,
                 bit'($urandom_range(0, 1)), $urandom, "R3");
        end

        sweep("R10");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule